// File: doc/BRIEF.md
# Current-Sense Short Detector

This block watches a switching power stage for a current-sense resistor that has been shorted, for example by a solder bridge. Each time the gate drive rises, it waits a fixed number of clock cycles and then takes one sample of the digitised current-sense code. That sample is compared against a threshold that is interpolated from the digitised line voltage. A sample below the threshold counts as low.

When a run of consecutive low samples reaches a set length, the block emits a one-cycle fault pulse. The surrounding sequencer treats this pulse as an auto-restart fault and stops switching at once. A debug output shows how long the current run of low samples is. A sequencer enable input clears the run whenever switching is disabled.

Top module: `current_sense_short_det`

## Requirements
- R1: A sample is taken at the clock edge that falls SAMPLE_DLY cycles after the edge at which `gate_i` is first seen high, and only if `gate_i` is still high at that edge.
- R2: If `gate_i` falls before the sample edge, no sample is taken and `low_cnt_o` keeps its value.
- R3: With `line_code_i` in volts (1 LSB = 1 V) and `cs_code_i` in millivolts (1 LSB = 1 mV), the threshold for line codes from 122 to 366 is 50 + floor((line − 122) × 50 / 244).
- R4: The threshold is clamped to 50 for line codes below 122 and to 100 for line codes above 366.
- R5: A sample strictly below the threshold is low and increments `low_cnt_o` at the sample edge.
- R6: A sample equal to or above the threshold resets `low_cnt_o` to 0. `low_cnt_o` never reaches RUN_LEN (default 11).
- R7: The RUN_LEN-th consecutive low sample raises `fault_o` for exactly one cycle, starting right after the sample edge, and returns `low_cnt_o` to 0.
- R8: While `sw_en_i` is low, `low_cnt_o` is held at 0, any pending sample is cancelled, and `fault_o` stays low.
- R9: After reset, `fault_o` is 0 and `low_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_en_i | input | 1 | Switching enabled by the sequencer |
| gate_i | input | 1 | Gate drive level |
| cs_code_i | input | CS_W | Current-sense code, mV |
| line_code_i | input | LINE_W | Line-voltage code, V |
| fault_o | output | 1 | Auto-restart fault pulse |
| low_cnt_o | output | CNT_W | Current length of the run of consecutive low samples |

## Verification
Some properties are checked by the assertions on every cycle:
- the fault pulse lasts exactly one cycle and leaves the run count at zero;
- the run count stays below RUN_LEN;
- the count holds between samples;
- disabling switching clears the count;
- a sample is only ever taken while the gate has been high;
- the threshold stays inside its clamp range.

Other behaviour can only be shown by the bench's pulse scenarios:
- the exact sample edge, including the off-by-one between a pulse one cycle too short and one just long enough;
- the strict comparison at the threshold;
- the interpolated and clamped threshold values at several line codes;
- the fault arriving on precisely the eleventh low pulse.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  function automatic int unsigned interp_thr(int unsigned line, int unsigned lo_l,
                                             int unsigned hi_l, int unsigned lo_t,
                                             int unsigned hi_t);
    if (line <= lo_l) return lo_t;
    if (line >= hi_l) return hi_t;
    return lo_t + ((line - lo_l) * (hi_t - lo_t)) / (hi_l - lo_l);
  endfunction
endpackage

// File: rtl/ssd_threshold.sv
module ssd_threshold #(
  parameter int LINE_W = 10,
  parameter int CS_W   = 10,
  parameter int LINE_LO = 122,
  parameter int LINE_HI = 366,
  parameter int THR_LO  = 50,
  parameter int THR_HI  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  output logic [CS_W-1:0]   thr_o
);
  logic [31:0] thr_full;

  always_comb begin
    thr_full = ssd_pkg::interp_thr(32'(line_i), LINE_LO, LINE_HI, THR_LO, THR_HI);
    thr_o    = thr_full[CS_W-1:0];
  end

  a_r4_thr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_o >= CS_W'(THR_LO)) && (thr_o <= CS_W'(THR_HI)));
endmodule

// File: rtl/ssd_sample_timer.sv
module ssd_sample_timer #(
  parameter int SAMPLE_DLY = 910
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic gate_i,
  output logic strobe_o
);
  localparam int CW = $clog2(SAMPLE_DLY + 1);

  logic          gate_q, armed_q, rise;
  logic [CW-1:0] cnt_q;

  assign rise     = gate_i & ~gate_q;
  assign strobe_o = armed_q & gate_i & en_i & (cnt_q == CW'(SAMPLE_DLY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      gate_q <= gate_i;
      if (!en_i) begin
        armed_q <= 1'b0;
      end else if (rise) begin
        armed_q <= 1'b1;
        cnt_q   <= CW'(1);
      end else if (armed_q) begin
        if (!gate_i || strobe_o) armed_q <= 1'b0;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // gate must have been high the cycle before any sample
  a_r1_strobe_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(gate_i));
endmodule

// File: rtl/ssd_run_counter.sv
module ssd_run_counter #(
  parameter int CS_W    = 10,
  parameter int RUN_LEN = 11,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             strobe_i,
  input  logic [CS_W-1:0]  cs_i,
  input  logic [CS_W-1:0]  thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fault_o
);
  logic is_low;
  assign is_low = cs_i < thr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      fault_o <= 1'b0;
    end else if (!en_i) begin
      cnt_o   <= '0;
      fault_o <= 1'b0;
    end else if (strobe_i) begin
      if (is_low && cnt_o == CNT_W'(RUN_LEN - 1)) begin
        cnt_o   <= '0;
        fault_o <= 1'b1;
      end else begin
        cnt_o   <= is_low ? cnt_o + 1'b1 : '0;
        fault_o <= 1'b0;
      end
    end else begin
      fault_o <= 1'b0;
    end
  end

  a_r7_fault_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  a_r7_fault_zero_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> cnt_o == '0);
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o < CNT_W'(RUN_LEN));
  a_r8_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_o == '0) && !fault_o);
  a_r2_hold_no_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !strobe_i) |=> $stable(cnt_o));
endmodule

// File: rtl/current_sense_short_det.sv
module current_sense_short_det #(
  parameter int SAMPLE_DLY = 910,
  parameter int RUN_LEN    = 11,
  parameter int CS_W       = 10,
  parameter int LINE_W     = 10,
  parameter int LINE_LO    = 122,
  parameter int LINE_HI    = 366,
  parameter int THR_LO     = 50,
  parameter int THR_HI     = 100,
  localparam int CNT_W     = $clog2(RUN_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_en_i,
  input  logic              gate_i,
  input  logic [CS_W-1:0]   cs_code_i,
  input  logic [LINE_W-1:0] line_code_i,
  output logic              fault_o,
  output logic [CNT_W-1:0]  low_cnt_o
);
  logic            strobe;
  logic [CS_W-1:0] thr;

  ssd_sample_timer #(.SAMPLE_DLY(SAMPLE_DLY)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sw_en_i), .gate_i(gate_i), .strobe_o(strobe)
  );

  ssd_threshold #(
    .LINE_W(LINE_W), .CS_W(CS_W), .LINE_LO(LINE_LO), .LINE_HI(LINE_HI),
    .THR_LO(THR_LO), .THR_HI(THR_HI)
  ) u_thr (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_code_i), .thr_o(thr)
  );

  ssd_run_counter #(.CS_W(CS_W), .RUN_LEN(RUN_LEN)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sw_en_i), .strobe_i(strobe),
    .cs_i(cs_code_i), .thr_i(thr), .cnt_o(low_cnt_o), .fault_o(fault_o)
  );
endmodule

// File: tb/current_sense_short_det_test.sv
`timescale 1ns/1ps
module current_sense_short_det_test;
  localparam int DLY = 8;
  localparam int RUN = 11;

  logic       clk = 0, rst_ni = 0, sw_en = 0, gate = 0;
  logic [9:0] cs = 0, line = 0;
  logic       fault;
  logic [3:0] low_cnt;

  typedef struct { int cnt; int faults; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, faults_seen = 0;
  int m_cnt = 0, m_faults = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  current_sense_short_det #(.SAMPLE_DLY(DLY)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_en_i(sw_en), .gate_i(gate),
    .cs_code_i(cs), .line_code_i(line), .fault_o(fault), .low_cnt_o(low_cnt)
  );

  function automatic int ref_thr(int l);
    if (l < 122) return 50;
    if (l > 366) return 100;
    return (50 * 244 + (l - 122) * 50) / 244;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: one gate pulse of `high` cycles
  task automatic pulse(int high, int c, int l, string tag);
    exp_t e;
    @(negedge clk);
    cs = 10'(c); line = 10'(l); gate = 1;
    repeat (high) @(negedge clk);
    gate = 0;
    repeat (4) @(negedge clk);
    if (sw_en && high >= DLY + 1) begin
      if (c < ref_thr(l)) begin
        if (m_cnt == RUN - 1) begin m_cnt = 0; m_faults++; end
        else m_cnt++;
      end else m_cnt = 0;
    end else if (!sw_en) m_cnt = 0;
    e.cnt = m_cnt; e.faults = m_faults; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) if (fault) faults_seen++;

  // monitor
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " cnt"}, int'(low_cnt), e.cnt);
      check({e.tag, " faults"}, faults_seen, e.faults);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset fault", int'(fault), 0);
    check("R9 reset cnt", int'(low_cnt), 0);
    rst_ni = 1; sw_en = 1;
    // R5 / R6 at line 244, threshold 75
    for (int i = 0; i < 5; i++) pulse(DLY + 2, 74, 244, "R5 low");
    pulse(DLY + 2, 75, 244, "R6 at-threshold reset");
    // R2 short pulse vs R1 just long enough
    for (int i = 0; i < 3; i++) pulse(DLY + 1, 10, 244, "R1 min pulse");
    pulse(DLY, 10, 244, "R2 short pulse");
    pulse(DLY, 99, 244, "R2 short high cs");
    pulse(DLY + 1, 10, 244, "R1 boundary");
    for (int i = 0; i < 7; i++) pulse(DLY + 3, 0, 244, "R7 run");
    pulse(DLY + 3, 0, 244, "R7 after fault");
    // R8 disable clears count and blocks sampling
    for (int i = 0; i < 3; i++) pulse(DLY + 2, 0, 244, "R8 prep");
    @(negedge clk); sw_en = 0;
    pulse(DLY + 2, 0, 244, "R8 disabled");
    @(negedge clk); sw_en = 1;
    // R4 clamp, R3 interpolation
    pulse(DLY + 2, 49, 0, "R4 clamp low below");
    pulse(DLY + 2, 50, 0, "R4 clamp low at");
    pulse(DLY + 2, 99, 1000, "R4 clamp high below");
    pulse(DLY + 2, 100, 1000, "R4 clamp high at");
    pulse(DLY + 2, 64, 200, "R3 interp 200 below");
    pulse(DLY + 2, 65, 200, "R3 interp 200 at");
    pulse(DLY + 2, 49, 122, "R3 endpoint 122 below");
    pulse(DLY + 2, 50, 122, "R3 endpoint 122 at");
    pulse(DLY + 2, 99, 366, "R3 endpoint 366 below");
    pulse(DLY + 2, 100, 366, "R3 endpoint 366 at");
    for (int i = 0; i < RUN; i++) pulse(DLY + 5, 0, 122, "R7 second fault");
    repeat (5) @(negedge clk);
    check("R7 total faults", faults_seen, 2);
    finish_run();
  end
endmodule